// File: doc/BRIEF.md
# Multi-Port Bus Performance Monitor

This block watches the request and completion traffic of several memory-request ports without taking part in it. Each port has its own address window, set in 8 KB pages over a 256 MB space. For every access that falls inside that window and matches the selected transaction kind, the block records a transfer count, a running latency sum and the largest latency it has seen. It also keeps latency sums indexed by the request's QoS level, summed over all ports. A global cycle counter runs while monitoring is active, so software can divide a port's latency sum or transfer count by elapsed cycles to get percentages.

Software drives the block through a small word-addressed register interface. One control word holds the enable, clear, run, kind-select and readback-select fields. There is one window register per port, and the counters are read back through a multiplexer. A port may have one transaction outstanding at a time. The latency of a transaction is the number of cycles from its request handshake to its final-beat pulse.

Top module: `perf_monitor`

## Requirements
- R1: After reset the control word reads 0x001 (enabled, not running), every window register reads 0x7FFF0000 (lower page 0, upper page 0x7FFF), and every counter reads 0.
- R2: A transaction is counted only if address bits [27:13] are at least the port's lower page and at most its upper page. Window register bits [14:0] hold the lower page and bits [30:16] hold the upper page.
- R3: Control bits [3:2] select the counted kind: 00 or 11 counts both, 01 counts reads only, 10 counts writes only. The kind is judged at completion.
- R4: A qualifying completion adds one to the port's transfer count and adds its latency to the port's latency sum. The latency is the number of cycles from the accepted request (valid and ready with the port idle) to the cycle whose rising edge samples the final-beat pulse.
- R5: The per-port maximum-latency register changes only when a completed latency is strictly greater than the stored value.
- R6: Each QoS level has a latency sum that adds the latencies of all qualifying completions carrying that level, including several ports completing in the same cycle.
- R7: Counting happens only while control bit 0 (enable) and bit 4 (run) are both set. Writing 0x001 stops counting and keeps every value.
- R8: While control bit 1 (clear) is set, all counters are forced to zero, and clearing wins over any increment in the same cycle.
- R9: Each port's information register returns the transfer count when control bits [11:8] equal 0x8, and the latency sum for any other value.
- R10: The cycle counter increases by one on every cycle in which counting is active, and holds otherwise.
- R11: Every counter saturates at all ones instead of wrapping.
- R12: Register map, by word address: 0 control, 1..4 window of port 0..3, 5..8 information of port 0..3, 9 cycle count, 10..13 maximum latency of port 0..3, 14..17 QoS sums of level 0..3. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| req_valid | input | 4 | Per-port request valid |
| req_ready | input | 4 | Per-port request ready |
| req_write | input | 4 | Per-port request is a write |
| req_addr | input | 112 | Per-port 28-bit request offset, port p at bits [28p+27:28p] |
| req_qos | input | 8 | Per-port 2-bit QoS level |
| resp_done | input | 4 | Per-port final data beat pulse |

## Verification
The assertions assume that each port has at most one transaction outstanding. They also assume that a final-beat pulse comes only after the request handshake has been accepted, in a later cycle, and never in the same cycle as a new request. The stimulus keeps to this: each port is driven by a task that raises valid for one cycle, waits out the latency, then pulses the final beat before the next request on that port. The bench is built with 10-bit counters so that saturation of the cycle count, the latency and the latency sums is reached within the run.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int CTL_W        = 12;
  localparam int CTL_EN       = 0;
  localparam int CTL_CLR      = 1;
  localparam int CTL_KIND_LSB = 2;
  localparam int CTL_RUN      = 4;
  localparam int CTL_SEL_LSB  = 8;
  localparam logic [CTL_W-1:0] CTL_MASK  = 12'hF1F;
  localparam logic [CTL_W-1:0] CTL_RESET = 12'h001;
  localparam logic [3:0]       SEL_XFERS = 4'h8;

  typedef enum logic [1:0] {
    KIND_ANY  = 2'b00,
    KIND_RD   = 2'b01,
    KIND_WR   = 2'b10,
    KIND_ANY2 = 2'b11
  } kind_e;

  typedef struct packed {
    logic       en;
    logic       clr;
    logic       run;
    kind_e      kind;
    logic [3:0] sel;
  } ctl_t;
endpackage

// File: rtl/pm_regs.sv
module pm_regs
  import pm_pkg::*;
#(
  parameter int NPORT = 4,
  parameter int WB    = 15,
  parameter int AW    = 5,
  parameter int DW    = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [AW-1:0]             addr,
  input  logic [DW-1:0]             wdata,
  output ctl_t                      ctl,
  output logic [CTL_W-1:0]          ctl_word,
  output logic [NPORT-1:0][WB-1:0]  win_lo,
  output logic [NPORT-1:0][WB-1:0]  win_hi
);
  localparam int CTL_ADDR = 0;
  localparam int WIN_BASE = 1;
  localparam int HI_LSB   = 16;

  logic [CTL_W-1:0]         ctl_q, ctl_d;
  logic [NPORT-1:0][WB-1:0] lo_q, lo_d, hi_q, hi_d;
  logic                     unused_wdata;

  assign unused_wdata = ^wdata;

  always_comb begin
    ctl_d = ctl_q;
    lo_d  = lo_q;
    hi_d  = hi_q;
    if (wr_en) begin
      if (addr == AW'(CTL_ADDR)) ctl_d = wdata[CTL_W-1:0] & CTL_MASK;
      for (int p = 0; p < NPORT; p++) begin
        if (addr == AW'(WIN_BASE + p)) begin
          lo_d[p] = wdata[WB-1:0];
          hi_d[p] = wdata[HI_LSB +: WB];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= CTL_RESET;
      lo_q  <= '0;
      hi_q  <= '1;
    end else if (wr_en) begin
      ctl_q <= ctl_d;
      lo_q  <= lo_d;
      hi_q  <= hi_d;
    end
  end

  assign ctl_word = ctl_q;
  assign ctl.en   = ctl_q[CTL_EN];
  assign ctl.clr  = ctl_q[CTL_CLR];
  assign ctl.run  = ctl_q[CTL_RUN];
  assign ctl.kind = kind_e'(ctl_q[CTL_KIND_LSB +: 2]);
  assign ctl.sel  = ctl_q[CTL_SEL_LSB +: 4];
  assign win_lo   = lo_q;
  assign win_hi   = hi_q;
endmodule

// File: rtl/pm_port.sv
module pm_port
  import pm_pkg::*;
#(
  parameter int ADDR_W    = 28,
  parameter int GRAN_BITS = 13,
  parameter int CNT_W     = 32,
  parameter int QOS_W     = 2,
  localparam int WB       = ADDR_W - GRAN_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [QOS_W-1:0]  req_qos,
  input  logic              resp_done,
  input  logic [WB-1:0]     win_lo,
  input  logic [WB-1:0]     win_hi,
  input  kind_e             kind,
  input  logic              active,
  input  logic              clear,
  output logic [CNT_W-1:0]  xfers,
  output logic [CNT_W-1:0]  lat_sum,
  output logic [CNT_W-1:0]  lat_max,
  output logic              ev_valid,
  output logic [CNT_W-1:0]  ev_lat,
  output logic [QOS_W-1:0]  ev_qos
);
  logic             busy_q, busy_d;
  logic [CNT_W-1:0] lat_q, lat_d;
  logic             hit_q, wr_q;
  logic [QOS_W-1:0] qos_q;
  logic [CNT_W-1:0] xfers_q, xfers_d, sum_q, sum_d, max_q, max_d;
  logic             accept, finish, in_win, kind_ok, cnt_en, trk_en;
  logic [WB-1:0]    page;
  logic [CNT_W:0]   sum_ext, xfer_ext;
  logic             unused_addr;

  assign unused_addr = ^req_addr[GRAN_BITS-1:0];
  assign page    = req_addr[ADDR_W-1:GRAN_BITS];
  assign in_win  = (page >= win_lo) && (page <= win_hi);
  assign accept  = req_valid && req_ready && !busy_q;
  assign finish  = busy_q && resp_done;
  assign kind_ok = wr_q ? (kind != KIND_RD) : (kind != KIND_WR);
  assign ev_valid = finish && hit_q && kind_ok && active;
  assign ev_lat   = lat_q;
  assign ev_qos   = qos_q;

  // tracker next state
  always_comb begin
    busy_d = busy_q;
    lat_d  = lat_q;
    if (finish) busy_d = 1'b0;
    if (accept) begin
      busy_d = 1'b1;
      lat_d  = CNT_W'(1);
    end else if (busy_q && !finish && (lat_q != '1)) begin
      lat_d = lat_q + CNT_W'(1);
    end
  end

  // counter next state
  assign xfer_ext = {1'b0, xfers_q} + (CNT_W+1)'(1);
  assign sum_ext  = {1'b0, sum_q} + {1'b0, lat_q};

  always_comb begin
    xfers_d = xfers_q;
    sum_d   = sum_q;
    max_d   = max_q;
    if (clear) begin
      xfers_d = '0;
      sum_d   = '0;
      max_d   = '0;
    end else if (ev_valid) begin
      xfers_d = xfer_ext[CNT_W] ? '1 : xfer_ext[CNT_W-1:0];
      sum_d   = sum_ext[CNT_W]  ? '1 : sum_ext[CNT_W-1:0];
      if (lat_q > max_q) max_d = lat_q;
    end
  end

  assign cnt_en = clear || ev_valid;
  assign trk_en = accept || busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      lat_q  <= '0;
    end else if (trk_en) begin
      busy_q <= busy_d;
      lat_q  <= lat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      wr_q  <= 1'b0;
      qos_q <= '0;
    end else if (accept) begin
      hit_q <= in_win;
      wr_q  <= req_write;
      qos_q <= req_qos;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfers_q <= '0;
      sum_q   <= '0;
      max_q   <= '0;
    end else if (cnt_en) begin
      xfers_q <= xfers_d;
      sum_q   <= sum_d;
      max_q   <= max_d;
    end
  end

  assign xfers   = xfers_q;
  assign lat_sum = sum_q;
  assign lat_max = max_q;
endmodule

// File: rtl/pm_qos.sv
module pm_qos #(
  parameter int NPORT = 4,
  parameter int CNT_W = 32,
  parameter int QOS_W = 2,
  localparam int NQOS = 1 << QOS_W,
  localparam int EXT  = CNT_W + $clog2(NPORT) + 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clear,
  input  logic [NPORT-1:0]             ev_valid,
  input  logic [NPORT-1:0][CNT_W-1:0]  ev_lat,
  input  logic [NPORT-1:0][QOS_W-1:0]  ev_qos,
  output logic [NQOS-1:0][CNT_W-1:0]   qsum
);
  logic [NQOS-1:0][CNT_W-1:0] q_q, q_d;
  logic [NQOS-1:0][EXT-1:0]   add, tot;
  logic                       q_en;

  always_comb begin
    for (int q = 0; q < NQOS; q++) begin
      add[q] = '0;
      for (int p = 0; p < NPORT; p++) begin
        if (ev_valid[p] && (ev_qos[p] == QOS_W'(q))) add[q] = add[q] + EXT'(ev_lat[p]);
      end
      tot[q] = EXT'(q_q[q]) + add[q];
      if (clear)                             q_d[q] = '0;
      else if (tot[q] > EXT'({CNT_W{1'b1}})) q_d[q] = '1;
      else                                   q_d[q] = tot[q][CNT_W-1:0];
    end
  end

  assign q_en = clear || (|ev_valid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_q <= '0;
    else if (q_en) q_q <= q_d;
  end

  assign qsum = q_q;
endmodule

// File: rtl/perf_monitor.sv
module perf_monitor
  import pm_pkg::*;
#(
  parameter int NPORT     = 4,
  parameter int ADDR_W    = 28,
  parameter int GRAN_BITS = 13,
  parameter int CNT_W     = 32,
  parameter int QOS_W     = 2,
  parameter int AW        = 5,
  parameter int DW        = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr,
  input  logic [AW-1:0]            reg_addr,
  input  logic [DW-1:0]            reg_wdata,
  output logic [DW-1:0]            reg_rdata,
  input  logic [NPORT-1:0]         req_valid,
  input  logic [NPORT-1:0]         req_ready,
  input  logic [NPORT-1:0]         req_write,
  input  logic [NPORT*ADDR_W-1:0]  req_addr,
  input  logic [NPORT*QOS_W-1:0]   req_qos,
  input  logic [NPORT-1:0]         resp_done
);
  localparam int WB        = ADDR_W - GRAN_BITS;
  localparam int NQOS      = 1 << QOS_W;
  localparam int CTL_ADDR  = 0;
  localparam int WIN_BASE  = 1;
  localparam int INFO_BASE = WIN_BASE + NPORT;
  localparam int CYC_ADDR  = INFO_BASE + NPORT;
  localparam int MAX_BASE  = CYC_ADDR + 1;
  localparam int QOS_BASE  = MAX_BASE + NPORT;

  logic [1:0]                 rst_sync_q;
  logic                       rst_int_n;
  ctl_t                       ctl;
  logic [CTL_W-1:0]           ctl_word;
  logic [NPORT-1:0][WB-1:0]   win_lo, win_hi;
  logic [NPORT-1:0][CNT_W-1:0] xfers, lat_sum, lat_max, ev_lat;
  logic [NPORT-1:0][QOS_W-1:0] ev_qos;
  logic [NPORT-1:0]           ev_valid;
  logic [NQOS-1:0][CNT_W-1:0] qsum;
  logic [CNT_W-1:0]           cyc_q, cyc_d;
  logic                       active, cyc_en;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pm_regs #(.NPORT(NPORT), .WB(WB), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .ctl(ctl), .ctl_word(ctl_word), .win_lo(win_lo), .win_hi(win_hi)
  );

  assign active = ctl.en && ctl.run && !ctl.clr;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    pm_port #(.ADDR_W(ADDR_W), .GRAN_BITS(GRAN_BITS), .CNT_W(CNT_W), .QOS_W(QOS_W)) u_port (
      .clk(clk), .rst_n(rst_int_n),
      .req_valid(req_valid[p]), .req_ready(req_ready[p]), .req_write(req_write[p]),
      .req_addr(req_addr[p*ADDR_W +: ADDR_W]), .req_qos(req_qos[p*QOS_W +: QOS_W]),
      .resp_done(resp_done[p]), .win_lo(win_lo[p]), .win_hi(win_hi[p]),
      .kind(ctl.kind), .active(active), .clear(ctl.clr),
      .xfers(xfers[p]), .lat_sum(lat_sum[p]), .lat_max(lat_max[p]),
      .ev_valid(ev_valid[p]), .ev_lat(ev_lat[p]), .ev_qos(ev_qos[p])
    );
  end

  pm_qos #(.NPORT(NPORT), .CNT_W(CNT_W), .QOS_W(QOS_W)) u_qos (
    .clk(clk), .rst_n(rst_int_n), .clear(ctl.clr),
    .ev_valid(ev_valid), .ev_lat(ev_lat), .ev_qos(ev_qos), .qsum(qsum)
  );

  // global cycle counter
  always_comb begin
    cyc_d = cyc_q;
    if (ctl.clr)            cyc_d = '0;
    else if (cyc_q != '1)   cyc_d = cyc_q + CNT_W'(1);
  end
  assign cyc_en = ctl.clr || active;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  cyc_q <= '0;
    else if (cyc_en) cyc_q <= cyc_d;
  end

  // readback multiplexer
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(CTL_ADDR)) reg_rdata = DW'(ctl_word);
    if (reg_addr == AW'(CYC_ADDR)) reg_rdata = DW'(cyc_q);
    for (int p = 0; p < NPORT; p++) begin
      if (reg_addr == AW'(WIN_BASE + p))  reg_rdata = (DW'(win_hi[p]) << 16) | DW'(win_lo[p]);
      if (reg_addr == AW'(INFO_BASE + p)) reg_rdata = (ctl.sel == SEL_XFERS) ? DW'(xfers[p]) : DW'(lat_sum[p]);
      if (reg_addr == AW'(MAX_BASE + p))  reg_rdata = DW'(lat_max[p]);
    end
    for (int q = 0; q < NQOS; q++) begin
      if (reg_addr == AW'(QOS_BASE + q))  reg_rdata = DW'(qsum[q]);
    end
  end
endmodule

// File: rtl/pm_checker.sv
module pm_checker #(
  parameter int NPORT = 4,
  parameter int CNT_W = 32
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         active,
  input logic                         clear,
  input logic [NPORT-1:0][CNT_W-1:0]  xfers,
  input logic [NPORT-1:0][CNT_W-1:0]  lat_max,
  input logic [CNT_W-1:0]             cycles
);
  for (genvar p = 0; p < NPORT; p++) begin : g_chk
    // R8
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (xfers[p] == '0) && (lat_max[p] == '0));
    // R5
    max_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |=> lat_max[p] >= $past(lat_max[p]));
    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !clear) |=> $stable(xfers[p]));
    // R11
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfers[p] == '1 && !clear) |=> xfers[p] == '1);
  end

  // R10
  cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cycles != '1) |=> cycles == $past(cycles) + CNT_W'(1));
  // R10
  cyc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !clear) |=> $stable(cycles));
  // R11
  cyc_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cycles == '1 && !clear) |=> cycles == '1);
endmodule

bind perf_monitor pm_checker #(.NPORT(NPORT), .CNT_W(CNT_W)) u_pm_checker (
  .clk(clk), .rst_n(rst_int_n), .active(active), .clear(ctl.clr),
  .xfers(xfers), .lat_max(lat_max), .cycles(cyc_q)
);

// File: tb/test_perf_monitor.sv
module test_perf_monitor;
  localparam int NP = 4, AWD = 28, CW = 10, QW = 2;
  localparam int SATV = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic reg_wr;
  logic [4:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [NP-1:0] req_valid, req_ready, req_write, resp_done;
  logic [NP*AWD-1:0] req_addr;
  logic [NP*QW-1:0] req_qos;

  int checks = 0, errors = 0;
  string tag = "R1";
  bit cmp_on = 1'b0;

  perf_monitor #(.CNT_W(CW)) i_perf_monitor (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_qos(req_qos), .resp_done(resp_done)
  );

  always #10 clk = ~clk;

  // behavioural reference model
  int m_ctl, m_lo[NP], m_hi[NP], m_busy[NP], m_lat[NP], m_hit[NP], m_wr[NP], m_q[NP];
  int m_cnt[NP], m_sum[NP], m_max[NP], m_qs[4], m_cyc;

  function automatic int sat(int v);
    return (v > SATV) ? SATV : v;
  endfunction

  function automatic logic [31:0] mread(int a);
    if (a == 0) return m_ctl;
    if (a >= 1 && a <= 4) return (m_hi[a-1] << 16) | m_lo[a-1];
    if (a >= 5 && a <= 8) return (((m_ctl >> 8) & 15) == 8) ? m_cnt[a-5] : m_sum[a-5];
    if (a == 9) return m_cyc;
    if (a >= 10 && a <= 13) return m_max[a-10];
    if (a >= 14 && a <= 17) return m_qs[a-14];
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctl = 1; m_cyc = 0;
      for (int p = 0; p < NP; p++) begin
        m_lo[p] = 0; m_hi[p] = 'h7FFF; m_busy[p] = 0; m_lat[p] = 0; m_hit[p] = 0;
        m_wr[p] = 0; m_q[p] = 0; m_cnt[p] = 0; m_sum[p] = 0; m_max[p] = 0;
      end
      for (int q = 0; q < 4; q++) m_qs[q] = 0;
    end else begin
      int kind, qadd[4];
      bit act, clr;
      clr  = m_ctl[1];
      act  = m_ctl[0] && m_ctl[4] && !clr;
      kind = (m_ctl >> 2) & 3;
      for (int q = 0; q < 4; q++) qadd[q] = 0;
      for (int p = 0; p < NP; p++) begin
        bit fin, okk;
        fin = m_busy[p] != 0 && resp_done[p];
        okk = m_wr[p] != 0 ? (kind != 1) : (kind != 2);
        if (clr) begin
          m_cnt[p] = 0; m_sum[p] = 0; m_max[p] = 0;
        end else if (fin && m_hit[p] != 0 && okk && act) begin
          m_cnt[p] = sat(m_cnt[p] + 1);
          m_sum[p] = sat(m_sum[p] + m_lat[p]);
          if (m_lat[p] > m_max[p]) m_max[p] = m_lat[p];
          qadd[m_q[p]] += m_lat[p];
        end
        if (fin) m_busy[p] = 0;
        if (req_valid[p] && req_ready[p] && m_busy[p] == 0 && !fin) begin
          int pg;
          pg = int'(req_addr[p*AWD +: AWD]) >> 13;
          m_busy[p] = 1; m_lat[p] = 1;
          m_hit[p] = (pg >= m_lo[p] && pg <= m_hi[p]) ? 1 : 0;
          m_wr[p] = req_write[p]; m_q[p] = int'(req_qos[p*QW +: QW]);
        end else if (m_busy[p] != 0) begin
          m_lat[p] = sat(m_lat[p] + 1);
        end
      end
      for (int q = 0; q < 4; q++) m_qs[q] = clr ? 0 : sat(m_qs[q] + qadd[q]);
      if (clr) m_cyc = 0; else if (act) m_cyc = sat(m_cyc + 1);
      if (reg_wr) begin
        if (reg_addr == 0) m_ctl = int'(reg_wdata) & 'hF1F;
        if (reg_addr >= 1 && reg_addr <= 4) begin
          m_lo[reg_addr-1] = int'(reg_wdata) & 'h7FFF;
          m_hi[reg_addr-1] = (int'(reg_wdata) >> 16) & 'h7FFF;
        end
      end
    end
  end

  // comparison on every clock, away from the edge
  always @(posedge clk) begin
    #5;
    if (cmp_on) begin
      checks++;
      if (reg_rdata !== mread(int'(reg_addr))) begin
        errors++;
        $display("FAIL %s addr %0d actual %h expected %h", tag, reg_addr, reg_rdata, mread(int'(reg_addr)));
      end
    end
  end

  task automatic wreg(int a, int d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 5'(a); reg_wdata = 32'(d);
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic expect_reg(int a, int exp, string rq);
    @(negedge clk); reg_addr = 5'(a);
    @(posedge clk); #6;
    checks++;
    if (reg_rdata !== 32'(exp)) begin
      errors++;
      $display("FAIL %s addr %0d actual %h expected %h", rq, a, reg_rdata, exp);
    end
  endtask

  task automatic scan_all();
    for (int a = 0; a < 20; a++) begin
      @(negedge clk); reg_addr = 5'(a);
    end
  endtask

  task automatic txn(int p, int a, bit wr, int q, int lat);
    @(negedge clk);
    req_valid[p] = 1'b1; req_write[p] = wr;
    req_addr[p*AWD +: AWD] = AWD'(a); req_qos[p*QW +: QW] = QW'(q);
    @(negedge clk); req_valid[p] = 1'b0;
    repeat (lat - 1) @(negedge clk);
    resp_done[p] = 1'b1;
    @(negedge clk); resp_done[p] = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    req_valid = '0; req_ready = '1; req_write = '0; req_addr = '0; req_qos = '0; resp_done = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    cmp_on = 1'b1;

    // R1 reset state, R12 map
    tag = "R1";
    expect_reg(0, 'h001, "R1");
    expect_reg(2, 'h7FFF0000, "R1");
    expect_reg(9, 0, "R1");
    tag = "R12"; scan_all();

    // R4 R9 R10 basic counting
    tag = "R4";
    wreg(0, 'h811);
    txn(0, 'h0000100, 1'b0, 1, 3);
    txn(0, 'h0123456, 1'b1, 1, 5);
    txn(2, 'hFFFFFFF, 1'b0, 3, 1);
    expect_reg(5, 2, "R9");
    expect_reg(7, 1, "R9");
    wreg(0, 'h011);
    expect_reg(5, 8, "R4");
    expect_reg(10, 5, "R5");
    tag = "R10"; scan_all();

    // R5 maximum updates only on strictly greater
    tag = "R5";
    txn(0, 'h10, 1'b0, 0, 5);
    expect_reg(10, 5, "R5");
    txn(0, 'h10, 1'b0, 0, 2);
    txn(0, 'h10, 1'b0, 0, 7);
    expect_reg(10, 7, "R5");

    // R2 window bounds, 8 KB pages 2..3
    tag = "R2";
    wreg(2, (3 << 16) | 2);
    expect_reg(2, 'h00030002, "R2");
    wreg(0, 'h811);
    txn(1, 'h3FFF, 1'b0, 0, 2);
    txn(1, 'h4000, 1'b0, 0, 2);
    txn(1, 'h7FFF, 1'b1, 0, 2);
    txn(1, 'h8000, 1'b1, 0, 2);
    expect_reg(6, 2, "R2");

    // R3 kind selection
    tag = "R3";
    wreg(0, 'h815);
    txn(3, 'h200, 1'b0, 0, 2);
    txn(3, 'h200, 1'b1, 0, 2);
    wreg(0, 'h819);
    txn(3, 'h200, 1'b0, 0, 3);
    txn(3, 'h200, 1'b1, 0, 3);
    expect_reg(8, 2, "R3");
    wreg(0, 'h81D);
    txn(3, 'h200, 1'b1, 0, 2);
    expect_reg(8, 3, "R3");

    // R6 same-cycle completions on one QoS level
    tag = "R6";
    wreg(0, 'h011);
    fork
      txn(0, 'h100, 1'b0, 2, 4);
      txn(1, 'h4000, 1'b1, 2, 4);
      txn(2, 'h100, 1'b0, 2, 4);
    join
    expect_reg(16, 12, "R6");
    scan_all();

    // R7 stop keeps values
    tag = "R7";
    wreg(0, 'h001);
    txn(0, 'h100, 1'b0, 0, 9);
    txn(2, 'h100, 1'b1, 1, 9);
    expect_reg(10, 7, "R7");
    scan_all();

    // R8 clear wins over completions
    tag = "R8";
    wreg(0, 'h013);
    fork
      txn(0, 'h100, 1'b0, 0, 3);
      txn(3, 'h100, 1'b1, 0, 3);
    join
    expect_reg(9, 0, "R8");
    expect_reg(10, 0, "R8");
    expect_reg(16, 0, "R8");
    scan_all();

    // R11 saturation of cycles, latency and sums
    tag = "R11";
    wreg(0, 'h011);
    txn(0, 'h100, 1'b0, 1, 1100);
    txn(0, 'h100, 1'b0, 1, 1100);
    expect_reg(9, SATV, "R11");
    expect_reg(10, SATV, "R11");
    expect_reg(5, SATV, "R11");
    expect_reg(15, SATV, "R11");
    scan_all();

    cmp_on = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule